// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial-memory protocol engine. When a write transaction opens, the engine gives a start pulse with the target byte address. It then strobes each received data byte. The block keeps those bytes in a 128-byte page latch, together with a per-offset loaded mask. The row is fixed by the address bits above the page offset. The offset advances only inside the page, so a long burst wraps and overwrites its own earlier bytes.

At a commit pulse with at least one byte loaded, the block raises a busy flag for a fixed number of clock ticks. This models the long programming time of a nonvolatile array. Inside that window the loaded bytes are copied into the storage array, one byte per clock, in ascending offset order. An abort, or a commit with nothing loaded, drops the latch and leaves busy low. The storage array is an inferred byte-wide memory that comes up holding 0xFF everywhere. It has one combinational read port for the protocol engine.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy and the array write enable are low, and every array location reads 0xFF.
- R2: All bytes of one transaction are stored in the row given by start-address bits [ADDR_W-1:7], whatever the start offset.
- R3: Each accepted byte advances only the 7-bit page offset. Past offset 127 it wraps to offset 0 of the same row, and a later byte replaces the earlier byte at the same offset.
- R4: A transaction may load from 1 to 128 bytes. Only loaded offsets are written, and the other bytes of the row keep their previous contents.
- R5: A commit pulse with bytes loaded raises busy on the next clock. Busy then stays high for exactly CYCLE_TICKS cycles. During that window the write enable pulses once per loaded offset, in ascending offset order.
- R6: An abort pulse discards the latched bytes, and so does a commit pulse with nothing loaded. Neither raises busy, and a later commit stores nothing.
- R7: While busy is high, start, byte, commit and abort pulses are ignored. They change neither the busy window nor the array, and they load nothing into the latch.
- R8: rd_data shows the array byte at rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Opens a write transaction at wr_addr |
| wr_addr | input | ADDR_W | Start byte address |
| byte_stb | input | 1 | Latches byte_data at the current offset |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Starts the timed write cycle |
| abort | input | 1 | Discards the latched transaction |
| busy | output | 1 | High during the write cycle |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data |

## Verification
The hardest case to reach is a transaction whose offset has wrapped. In that case the loaded mask covers the whole page, but some entries have been overwritten. The bench starts a burst of 130 bytes at offset 0, so the first two offsets get replaced. It then checks the whole row through the read port. Pulses sent in the middle of the busy window are checked in two ways: the busy length must be unchanged, and a following commit must raise no busy, which proves that nothing was loaded.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W      = 11,
  parameter int OFS_W       = 7,
  parameter int CYCLE_TICKS = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              commit,
  input  logic              abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int PAGE  = 1 << OFS_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(CYCLE_TICKS) + 1;

  logic [7:0]       mem    [DEPTH];
  logic [7:0]       page_q [PAGE];
  logic [PAGE-1:0]  loaded;
  logic [ROW_W-1:0] row_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] tick_q;
  logic             busy_q;

  wire [OFS_W-1:0] scan      = tick_q[OFS_W-1:0];
  wire             in_scan   = tick_q < CNT_W'(PAGE);
  wire             last_tick = tick_q == CNT_W'(CYCLE_TICKS - 1);
  wire             take_byte = !busy_q && !abort && !commit && !wr_start && byte_stb;

  assign busy      = busy_q;
  assign mem_we    = busy_q && in_scan && loaded[scan];
  assign mem_waddr = {row_q, scan};
  assign mem_wdata = page_q[scan];
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      loaded <= '0;
      row_q  <= '0;
      ofs_q  <= '0;
    end else if (busy_q) begin
      tick_q <= tick_q + 1'b1;
      if (last_tick) begin
        busy_q <= 1'b0;
        tick_q <= '0;
        loaded <= '0;
      end
    end else if (abort) begin
      loaded <= '0;
    end else if (commit) begin
      if (|loaded) begin
        busy_q <= 1'b1;
        tick_q <= '0;
      end
    end else if (wr_start) begin
      row_q  <= wr_addr[ADDR_W-1:OFS_W];
      ofs_q  <= wr_addr[OFS_W-1:0];
      loaded <= '0;
    end else if (byte_stb) begin
      loaded[ofs_q] <= 1'b1;
      ofs_q         <= ofs_q + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (take_byte) page_q[ofs_q] <= byte_data;

  initial
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_waddr] <= mem_wdata;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W      = 11,
  parameter int OFS_W       = 7,
  parameter int CYCLE_TICKS = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  localparam int RUN_W = $clog2(CYCLE_TICKS + 2) + 1;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk)
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;

  assert_write_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_busy_not_too_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RUN_W'(CYCLE_TICKS));
  assert_busy_full_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RUN_W'(CYCLE_TICKS));
  assert_busy_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));
  assert_row_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_waddr[ADDR_W-1:OFS_W]));
  assert_ascending_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      mem_waddr[OFS_W-1:0] == $past(mem_waddr[OFS_W-1:0]) + 1'b1);
endmodule

bind page_write_buffer pwb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CYCLE_TICKS(CYCLE_TICKS)) u_pwb_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .busy(busy),
  .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
  localparam int AW = 11;
  localparam int TICKS = 300;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, byte_stb = 0, commit = 0, abort = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata, rd_data;

  int tests = 0, fails = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] pend [128];
  logic [127:0] pmask;
  logic [3:0] cur_row;
  logic [6:0] cur_ofs;

  always #4 clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .OFS_W(7), .CYCLE_TICKS(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .commit(commit), .abort(abort),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_start = 0; byte_stb = 0; commit = 0; abort = 0;
  endtask

  task automatic begin_txn(int addr);
    @(negedge clk); clear_inputs(); wr_start = 1; wr_addr = AW'(addr);
    cur_row = addr[10:7]; cur_ofs = addr[6:0]; pmask = '0;
    @(negedge clk); clear_inputs();
  endtask

  task automatic send(logic [7:0] b);
    byte_stb = 1; byte_data = b;
    pend[cur_ofs] = b; pmask[cur_ofs] = 1'b1; cur_ofs = cur_ofs + 1'b1;
    @(negedge clk); clear_inputs();
  endtask

  task automatic do_abort();
    abort = 1; pmask = '0;
    @(negedge clk); clear_inputs();
  endtask

  task automatic commit_and_wait(string req, bit noise);
    int n, w, expw;
    bit expect_busy;
    expect_busy = (pmask != 0);
    expw = $countones(pmask);
    for (int i = 0; i < 128; i++)
      if (pmask[i]) model[{cur_row, 7'(i)}] = pend[i];
    commit = 1;
    @(negedge clk); clear_inputs();
    check({req, " busy after commit"}, busy, expect_busy);
    n = 0; w = 0;
    while (busy) begin
      n++;
      if (mem_we) w++;
      if (noise && n == 5) begin wr_start = 1; wr_addr = 11'h7F0; end
      if (noise && n > 5 && n < 20) begin byte_stb = 1; byte_data = 8'(n); end
      if (noise && n == 30) commit = 1;
      if (noise && n == 40) abort = 1;
      @(negedge clk); clear_inputs();
    end
    check({req, " busy length"}, n, expect_busy ? TICKS : 0);
    check({req, " write count"}, w, expw);
    pmask = '0;
  endtask

  task automatic check_row(string req, int row);
    int bad;
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      rd_addr = AW'({row[3:0], 7'(i)});
      #1;
      if (rd_data !== model[{row[3:0], 7'(i)}]) begin
        if (bad == 0)
          $display("FAIL %s: row %0d ofs %0d actual %0h expected %0h",
                   req, row, i, rd_data, model[{row[3:0], 7'(i)}]);
        bad++;
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic t_reset();
    check("R1 busy at reset", busy, 0);
    check("R1 mem_we at reset", mem_we, 0);
    rd_addr = 11'h000; #1; check("R1/R8 erased byte", rd_data, 8'hFF);
    rd_addr = 11'h7FF; #1; check("R1/R8 erased byte", rd_data, 8'hFF);
  endtask

  task automatic t_single_byte();
    begin_txn(11'h105);
    send(8'h3C);
    commit_and_wait("R5 single", 0);
    check_row("R2/R4 single byte row", 2);
    rd_addr = 11'h105; #1; check("R8 single byte readback", rd_data, 8'h3C);
  endtask

  task automatic t_page_wrap();
    begin_txn(11'h190);
    for (int i = 0; i < 128; i++) send(8'(i * 3 + 1));
    commit_and_wait("R3 full page", 0);
    check_row("R3 full page wrapped from offset 16", 3);
  endtask

  task automatic t_overflow();
    begin_txn(11'h280);
    for (int i = 0; i < 130; i++) send(8'(i ^ 8'h5A));
    commit_and_wait("R3 overflow", 0);
    check_row("R3 overwrite after wrap", 5);
    rd_addr = 11'h280; #1; check("R3 offset 0 overwritten", rd_data, 8'(128 ^ 8'h5A));
  endtask

  task automatic t_sparse();
    begin_txn(11'h1A0);
    send(8'hA1); send(8'hA2); send(8'hA3);
    commit_and_wait("R4 sparse", 0);
    check_row("R4 unloaded offsets keep old data", 3);
  endtask

  task automatic t_abort_empty();
    begin_txn(11'h300);
    send(8'h11); send(8'h22);
    do_abort();
    commit_and_wait("R6 after abort", 0);
    check_row("R6 aborted row unchanged", 6);
    begin_txn(11'h310);
    commit_and_wait("R6 empty commit", 0);
  endtask

  task automatic t_busy_ignore();
    begin_txn(11'h400);
    send(8'h77);
    commit_and_wait("R7 noisy cycle", 1);
    check_row("R7 target row", 8);
    check_row("R7 ignored start row", 15);
    commit_and_wait("R7 nothing latched during busy", 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    pmask = '0; cur_row = '0; cur_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_page_wrap();
    t_overflow();
    t_sparse();
    t_abort_empty();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule